// File: doc/BRIEF.md
# Successive-Approximation ADC Controller with Threshold-Gated Interrupt

This block holds the digital side of a 10-bit successive-approximation analog-to-digital converter. A start request names one of twelve analog channels. The controller spends one cycle in sample-and-hold and then runs ten compare cycles. In each compare cycle it presents a trial code to an external compare DAC and reads back a 1-bit comparator decision. Bits are resolved from the most significant down to the least significant.

Once the last bit is decided, the code is written into that channel's 16-bit result register, left-justified. The completion interrupt then pulses for one cycle. When threshold compare is enabled, the interrupt only fires if the upper eight result bits meet the selected condition against an 8-bit threshold. The selectable conditions are "at or above the threshold" and "below the threshold". Software or a neighbouring block can read any channel's result at any time through a combinational read port.

Top module: `sar_adc_ctl`

## Requirements
- R1: When idle, a start request with a channel number 0 to 11 is accepted. `busy_o` is then high for exactly 12 cycles, beginning in the cycle after the request. A start request with a channel number of 12 or more is ignored, and `busy_o` stays low.
- R2: A start request that arrives while `busy_o` is high is ignored. The conversion in flight completes into its own channel, and the channel named by the ignored request is left unchanged.
- R3: `sample_o` is high in the first busy cycle only. In the second busy cycle `dac_code_o` carries the first trial code 0x200, which has only bit 9 set. Outside the compare cycles `dac_code_o` is 0.
- R4: At each step the trial code is the decided upper bits with the current bit set. A comparator value `cmp_below_i` = 1 clears that bit and a value of 0 keeps it. With an ideal comparator, the stored code therefore equals the input level.
- R5: The result goes into the channel's register on the edge where `busy_o` falls. The 10-bit code occupies bits 15:6, and bits 5:0 read as zero. Registers of other channels do not change.
- R6: After reset all result registers read 0. A read of channel 12 to 15 returns 0.
- R7: With threshold compare off (`pf_en_i` = 0), `irq_o` is high for exactly one cycle after every conversion. That cycle is the first cycle in which `busy_o` is low again.
- R8: With `pf_en_i` = 1 and `pf_ge_i` = 1, the pulse occurs only if result bits 15:8 are greater than or equal to `thresh_i`.
- R9: With `pf_en_i` = 1 and `pf_ge_i` = 0, the pulse occurs only if result bits 15:8 are less than `thresh_i`.
- R10: While reset is asserted and right after it, `busy_o`, `sample_o` and `irq_o` are 0 and `dac_code_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start request, sampled on each rising edge |
| chan_i | input | 4 | Channel to convert, taken with an accepted start |
| cmp_below_i | input | 1 | Comparator: 1 when the held input is below the DAC output |
| pf_en_i | input | 1 | Threshold compare enable |
| pf_ge_i | input | 1 | Condition select: 1 fires when the result is at or above the threshold, 0 fires when it is below |
| thresh_i | input | 8 | Threshold compared with result bits 15:8 |
| rd_chan_i | input | 4 | Channel selected on the read port |
| dac_code_o | output | 10 | Trial code sent to the compare DAC |
| sample_o | output | 1 | Sample-and-hold strobe |
| busy_o | output | 1 | Conversion in progress |
| irq_o | output | 1 | Completion interrupt pulse |
| rd_data_o | output | 16 | Left-justified result of the selected channel |

## Verification
The hardest case is a start request that lands in the middle of a conversion. To reach it, the stimulus raises `start_i` again with a different channel number during a compare cycle. It then confirms three things: the busy window still lasts 12 cycles, the original channel receives the code, and the second channel still reads zero. The threshold conditions are reached by choosing input levels whose upper byte sits exactly at the threshold, one below it, or at the extremes 0x00 and 0xFF. A behavioural comparator in the bench answers each trial code against that level, so every decision path of the search runs.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2,
    ST_DONE   = 2'd3
  } seq_state_e;

endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_adc_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int NUM_CH = 12,
  parameter int CH_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic             cmp_below_i,
  output logic [RES_W-1:0] dac_code_o,
  output logic             sample_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] code_o,
  output logic [CH_W-1:0]  chan_o
);

  localparam int STEP_W = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam logic [STEP_W-1:0] TOP_STEP = STEP_W'(RES_W - 1);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [RES_W-1:0]  sar_q, sar_d;
  logic [CH_W-1:0]   chan_q, chan_d;
  logic [RES_W-1:0]  bit_mask;
  logic [RES_W-1:0]  trial;
  logic              chan_ok;

  assign chan_ok  = (32'(chan_i) < NUM_CH);
  assign bit_mask = RES_W'(1) << step_q;
  assign trial    = sar_q | bit_mask;

  // next-state process
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    sar_d   = sar_q;
    chan_d  = chan_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i && chan_ok) begin
          state_d = ST_SAMPLE;
          chan_d  = chan_i;
          sar_d   = '0;
        end
      end
      ST_SAMPLE: begin
        state_d = ST_CONV;
        step_d  = TOP_STEP;
      end
      ST_CONV: begin
        sar_d = cmp_below_i ? sar_q : trial;
        if (step_q == '0) begin
          state_d = ST_DONE;
        end else begin
          step_d = step_q - 1'b1;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      sar_q   <= '0;
      chan_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      sar_q   <= sar_d;
      chan_q  <= chan_d;
    end
  end

  assign dac_code_o = (state_q == ST_CONV) ? trial : '0;
  assign sample_o   = (state_q == ST_SAMPLE);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign code_o     = sar_q;
  assign chan_o     = chan_q;

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i && chan_ok) |=> sample_o); // R1

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(chan_q)); // R2

  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> (dac_code_o == bit_mask && step_q == TOP_STEP)); // R3

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV && step_q != '0) |=> (step_q == $past(step_q) - 1'b1)); // R4

endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank #(
  parameter int NUM_CH = 12,
  parameter int RES_W  = 10,
  parameter int REG_W  = 16,
  parameter int CH_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [CH_W-1:0]  wr_chan_i,
  input  logic [RES_W-1:0] wr_code_i,
  input  logic [CH_W-1:0]  rd_chan_i,
  output logic [REG_W-1:0] rd_data_o
);

  localparam int PAD_W = REG_W - RES_W;

  logic [RES_W-1:0] slot_q [NUM_CH];
  logic             rd_ok;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en_i && (32'(wr_chan_i) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (slot_en) begin
        slot_q[g] <= wr_code_i;
      end
    end
  end

  assign rd_ok = (32'(rd_chan_i) < NUM_CH);

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_ok && 32'(rd_chan_i) == i) begin
        rd_data_o = {slot_q[i], {PAD_W{1'b0}}};
      end
    end
  end

  AST_WR_CHAN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> (32'(wr_chan_i) < NUM_CH)); // R1

endmodule

// File: rtl/sar_fail_cmp.sv
module sar_fail_cmp #(
  parameter int RES_W = 10,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  input  logic [RES_W-1:0] code_i,
  input  logic             pf_en_i,
  input  logic             pf_ge_i,
  input  logic [THR_W-1:0] thresh_i,
  output logic             irq_o
);

  logic [THR_W-1:0] upper;
  logic             hit;
  logic             irq_d, irq_q;

  assign upper = code_i[RES_W-1 -: THR_W];
  assign hit   = pf_ge_i ? (upper >= thresh_i) : (upper < thresh_i);

  always_comb begin
    irq_d = 1'b0;
    if (done_i) begin
      irq_d = !pf_en_i || hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R7

  AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(done_i)); // R7

  AST_PF_GE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && pf_en_i && pf_ge_i && upper < thresh_i) |=> !irq_o); // R8

  AST_PF_LT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && pf_en_i && !pf_ge_i && upper >= thresh_i) |=> !irq_o); // R9

endmodule

// File: rtl/sar_adc_ctl.sv
module sar_adc_ctl #(
  parameter int RES_W  = 10,
  parameter int NUM_CH = 12,
  parameter int REG_W  = 16,
  parameter int THR_W  = 8,
  parameter int CH_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic             cmp_below_i,
  input  logic             pf_en_i,
  input  logic             pf_ge_i,
  input  logic [THR_W-1:0] thresh_i,
  input  logic [CH_W-1:0]  rd_chan_i,
  output logic [RES_W-1:0] dac_code_o,
  output logic             sample_o,
  output logic             busy_o,
  output logic             irq_o,
  output logic [REG_W-1:0] rd_data_o
);

  logic             rst_sync_n;
  logic             done;
  logic [RES_W-1:0] code;
  logic [CH_W-1:0]  conv_chan;

  sar_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sar_seq #(.RES_W(RES_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_i     (start_i),
    .chan_i      (chan_i),
    .cmp_below_i (cmp_below_i),
    .dac_code_o  (dac_code_o),
    .sample_o    (sample_o),
    .busy_o      (busy_o),
    .done_o      (done),
    .code_o      (code),
    .chan_o      (conv_chan)
  );

  sar_result_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W), .REG_W(REG_W), .CH_W(CH_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (done),
    .wr_chan_i (conv_chan),
    .wr_code_i (code),
    .rd_chan_i (rd_chan_i),
    .rd_data_o (rd_data_o)
  );

  sar_fail_cmp #(.RES_W(RES_W), .THR_W(THR_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .done_i   (done),
    .code_i   (code),
    .pf_en_i  (pf_en_i),
    .pf_ge_i  (pf_ge_i),
    .thresh_i (thresh_i),
    .irq_o    (irq_o)
  );

  AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o |-> !busy_o); // R7

  AST_WRITE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !busy_o); // R5

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> (!busy_o && !irq_o && !sample_o && dac_code_o == '0)); // R10

endmodule

// File: tb/sar_adc_ctl_bench.sv
`timescale 1ns/1ps
module sar_adc_ctl_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [3:0]  chan_i;
  logic        cmp_below_i;
  logic        pf_en_i;
  logic        pf_ge_i;
  logic [7:0]  thresh_i;
  logic [3:0]  rd_chan_i;
  logic [9:0]  dac_code_o;
  logic        sample_o;
  logic        busy_o;
  logic        irq_o;
  logic [15:0] rd_data_o;
  logic [9:0]  vin;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  // ideal comparator: held input below the DAC output
  assign cmp_below_i = (vin < dac_code_o);

  sar_adc_ctl u_sar_adc_ctl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
    .cmp_below_i(cmp_below_i), .pf_en_i(pf_en_i), .pf_ge_i(pf_ge_i),
    .thresh_i(thresh_i), .rd_chan_i(rd_chan_i), .dac_code_o(dac_code_o),
    .sample_o(sample_o), .busy_o(busy_o), .irq_o(irq_o), .rd_data_o(rd_data_o)
  );

  // row: chan[24:21] vin[20:11] pf_en[10] pf_ge[9] thresh[8:1] exp_irq[0]
  localparam logic [24:0] VEC [8] = '{
    {4'd0,  10'h3FF, 1'b0, 1'b0, 8'h00, 1'b1},
    {4'd1,  10'h000, 1'b0, 1'b1, 8'hFF, 1'b1},
    {4'd5,  10'h155, 1'b1, 1'b1, 8'h55, 1'b1},
    {4'd6,  10'h150, 1'b1, 1'b1, 8'h55, 1'b0},
    {4'd7,  10'h150, 1'b1, 1'b0, 8'h55, 1'b1},
    {4'd8,  10'h157, 1'b1, 1'b0, 8'h55, 1'b0},
    {4'd11, 10'h2AA, 1'b1, 1'b1, 8'hFF, 1'b0},
    {4'd10, 10'h001, 1'b1, 1'b0, 8'h00, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic read_chan(input logic [3:0] ch, input string req, input logic [15:0] exp);
    rd_chan_i = ch;
    #1;
    check(req, rd_data_o, exp);
  endtask

  // one conversion; optionally a second start with another channel mid-way
  task automatic convert(input logic [3:0] ch, input logic [9:0] level,
                         input logic en, input logic ge, input logic [7:0] th,
                         input logic exp_irq, input logic poke, input logic [3:0] poke_ch);
    int cnt;
    @(negedge clk);
    vin = level; chan_i = ch; pf_en_i = en; pf_ge_i = ge; thresh_i = th;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R3 sample strobe", sample_o, 1'b1);
    cnt = 0;
    while (busy_o && cnt < 40) begin
      cnt++;
      if (cnt == 2) check("R3 first trial", dac_code_o, 10'h200);
      if (cnt == 3) check("R3 sample one cycle", sample_o, 1'b0);
      if (poke && cnt == 5) begin
        chan_i = poke_ch; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    check("R1 busy length", cnt, 12);
    check("R7 R8 R9 irq at completion", irq_o, exp_irq);
    read_chan(ch, "R4 R5 stored code", {level, 6'b0});
    @(negedge clk);
    check("R7 irq single cycle", irq_o, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; chan_i = '0; pf_en_i = 1'b0; pf_ge_i = 1'b0;
    thresh_i = '0; rd_chan_i = '0; vin = '0;
    repeat (3) @(negedge clk);
    check("R10 busy in reset", busy_o, 1'b0);
    check("R10 irq in reset", irq_o, 1'b0);
    check("R10 dac in reset", dac_code_o, 10'h000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 sample after reset", sample_o, 1'b0);
    read_chan(4'd3, "R6 reset value", 16'h0000);
    read_chan(4'd11, "R6 reset value top", 16'h0000);

    // vector table
    for (int i = 0; i < 8; i++) begin
      convert(VEC[i][24:21], VEC[i][20:11], VEC[i][10], VEC[i][9], VEC[i][8:1],
              VEC[i][0], 1'b0, 4'd0);
    end

    // R5: earlier channels untouched by later writes
    read_chan(4'd0, "R5 other channel kept", 16'hFFC0);
    read_chan(4'd5, "R5 other channel kept", {10'h155, 6'b0});

    // R6: out-of-range read
    read_chan(4'd12, "R6 read ch12", 16'h0000);
    read_chan(4'd15, "R6 read ch15", 16'h0000);

    // R1: invalid channel start ignored
    @(negedge clk);
    chan_i = 4'd13; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R1 invalid channel ignored", busy_o, 1'b0);
    @(negedge clk);
    check("R1 invalid channel no irq", irq_o, 1'b0);

    // R2: start while busy ignored
    convert(4'd2, 10'h0F0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 4'd3);
    read_chan(4'd3, "R2 poked channel untouched", 16'h0000);

    // R4: overwrite a channel with a new level
    convert(4'd0, 10'h201, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 4'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule